// File: doc/BRIEF.md
# Completion Timeout Monitor with Split Enables

This block watches the non-posted requests that a PCI Express-style port sends out and reports when one of them waits too long for its completion. Each request tag has its own age counter. The counter clears when a request is issued on that tag and advances on every pulse of a free-running tick input. When the age of an outstanding request reaches a programmed limit, and timeouts are enabled for that request's class, the block emits a one-cycle error pulse that carries the tag. The tag is then free for reuse.

Two bits of a control word enable timeouts. One bit governs ordinary (non-configuration) requests. The other governs configuration requests, but only while the ordinary enable is also set. A request whose class is disabled waits indefinitely for its completion and never raises the error. This lets a slow device deep in a hierarchy answer configuration accesses without false errors. The usual setting is configuration timeouts off and ordinary timeouts on. Both enables read as 0 out of reset.

Top module: `cpl_timeout_monitor`

## Requirements
- R1: After reset, no tag is outstanding, `tmo_pulse` and `proto_err` are 0, and both enables read as 0 until a control word is sampled.
- R2: An issue on a tag that is not outstanding sets that tag's bit in `outstanding`. A completion on an outstanding tag clears it. A completion on a tag that is not outstanding changes nothing.
- R3: When `ctl_word` bit 22 is 1, an ordinary request times out. Its age counter clears at issue and adds one at each clock edge where `tick` is 1. `tmo_pulse` rises on the edge after the edge at which the age first equals `limit`.
- R4: A configuration request (`req_is_cfg`=1) times out only when `ctl_word` bit 23 and bit 22 are both 1.
- R5: While its class is disabled, a request never raises `tmo_pulse` and stays outstanding until its completion arrives, however far its age has passed the limit.
- R6: A timeout is a single-cycle `tmo_pulse` with the tag on `tmo_tag`. On the same edge, that tag leaves `outstanding`.
- R7: A completion that arrives in the cycle in which its tag would time out takes priority. The tag is cleared and no pulse is raised.
- R8: An issue on a tag that is already outstanding is ignored: the age and class of the tag are kept. It sets `proto_err`, which stays 1 until reset.
- R9: The control word is sampled at every clock edge. A change applies to requests that are already outstanding, starting with the cycle after the edge that samples it.
- R10: When several tags expire in the same cycle, the lowest-numbered tag is reported first, one tag per cycle. The other tags stay outstanding until their own turn.
- R11: The age counter saturates at 2^AGE_W-1 and does not wrap. A long-outstanding request therefore still meets any limit once it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request issue strobe |
| req_tag | input | TAG_W | Tag of the issued request |
| req_is_cfg | input | 1 | Issued request is a configuration access |
| cpl_vld | input | 1 | Completion return strobe |
| cpl_tag | input | TAG_W | Tag of the returned completion |
| tick | input | 1 | Age advance strobe |
| ctl_word | input | CTL_W | Control word holding the two enable bits |
| limit | input | AGE_W | Timeout limit in ticks |
| tmo_pulse | output | 1 | One-cycle timeout error |
| tmo_tag | output | TAG_W | Tag that timed out |
| outstanding | output | NTAGS | Per-tag outstanding vector |
| proto_err | output | 1 | Sticky duplicate-issue flag |

## Verification
Issue and completion show up in `outstanding` right after the edge that samples them. A timeout pulse is due one edge after the edge that brings the age to `limit`, so the bench checks that the tag is still outstanding with no pulse after that edge, then checks the pulse one edge later. A change to the enables is sampled on one edge and can produce a pulse on the next edge at the earliest, and the bench checks on both sides of that boundary. The bench sweeps every tag, both classes and all four enable combinations. It drives inputs and reads outputs one time unit after each rising edge, so each check falls in a known cycle.

// File: rtl/cto_pkg.sv
package cto_pkg;

   typedef struct packed {
      logic cfg_en;
      logic ncfg_en;
   } cto_en_t;

   // configuration class needs both enables; ordinary class needs only its own
   function automatic logic cto_class_on(cto_en_t en, logic is_cfg);
      return en.ncfg_en && (!is_cfg || en.cfg_en);
   endfunction

endpackage

// File: rtl/cto_tag_slot.sv
module cto_tag_slot
   import cto_pkg::*;
#(
   parameter int AGE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue,
   input  logic             issue_cfg,
   input  logic             cpl_hit,
   input  logic             retire,
   input  logic             tick,
   input  logic [AGE_W-1:0] limit,
   input  cto_en_t          en,
   output logic             out_q,
   output logic             expired
);
   localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

   logic             cfg_q;
   logic [AGE_W-1:0] age_q;
   logic             cls_en;

   assign cls_en  = cto_class_on(en, cfg_q);
   assign expired = out_q && (age_q >= limit) && cls_en && !cpl_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= 1'b0;
         cfg_q <= 1'b0;
         age_q <= '0;
      end else if (!out_q) begin
         if (issue) begin
            out_q <= 1'b1;
            cfg_q <= issue_cfg;
            age_q <= '0;
         end
      end else if (cpl_hit || retire) begin
         out_q <= 1'b0;
      end else if (tick && (age_q != AGE_MAX)) begin
         age_q <= age_q + 1'b1;
      end
   end

   // R5
   disabled_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_q && !cls_en && !cpl_hit) |=> out_q);

   // R11
   age_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_q && age_q == AGE_MAX && !cpl_hit && !retire) |=> (age_q == AGE_MAX));

endmodule

// File: rtl/cto_pick.sv
module cto_pick #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     grant,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
      any   = |req;
      grant = '0;
      if (any) grant[idx] = 1'b1;
   end
endmodule

// File: rtl/cpl_timeout_monitor.sv
module cpl_timeout_monitor
   import cto_pkg::*;
#(
   parameter int NTAGS       = 8,
   parameter int AGE_W       = 8,
   parameter int CTL_W       = 32,
   parameter int NCFG_EN_POS = 22,
   parameter int CFG_EN_POS  = 23,
   localparam int TAG_W      = $clog2(NTAGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_vld,
   input  logic [TAG_W-1:0] req_tag,
   input  logic             req_is_cfg,
   input  logic             cpl_vld,
   input  logic [TAG_W-1:0] cpl_tag,
   input  logic             tick,
   input  logic [CTL_W-1:0] ctl_word,
   input  logic [AGE_W-1:0] limit,
   output logic             tmo_pulse,
   output logic [TAG_W-1:0] tmo_tag,
   output logic [NTAGS-1:0] outstanding,
   output logic             proto_err
);
   if (NTAGS < 2 || NTAGS != (1 << TAG_W)) begin : g_bad_ntags
      $error("NTAGS must be a power of two, at least 2");
   end
   if (AGE_W < 1) begin : g_bad_age
      $error("AGE_W must be positive");
   end
   if (NCFG_EN_POS >= CTL_W || CFG_EN_POS >= CTL_W || NCFG_EN_POS == CFG_EN_POS) begin : g_bad_pos
      $error("enable bit positions must be distinct and inside ctl_word");
   end

   cto_en_t          en_q;
   logic [NTAGS-1:0] expired;
   logic [NTAGS-1:0] grant;
   logic             any_exp;
   logic [TAG_W-1:0] pick_idx;
   logic             unused_ctl;

   assign unused_ctl = ^ctl_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else begin
         en_q.ncfg_en <= ctl_word[NCFG_EN_POS];
         en_q.cfg_en  <= ctl_word[CFG_EN_POS];
      end
   end

   for (genvar i = 0; i < NTAGS; i++) begin : g_slot
      cto_tag_slot #(.AGE_W(AGE_W)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .issue     (req_vld && (req_tag == TAG_W'(i))),
         .issue_cfg (req_is_cfg),
         .cpl_hit   (cpl_vld && (cpl_tag == TAG_W'(i))),
         .retire    (grant[i]),
         .tick      (tick),
         .limit     (limit),
         .en        (en_q),
         .out_q     (outstanding[i]),
         .expired   (expired[i])
      );
   end

   cto_pick #(.N(NTAGS), .IDX_W(TAG_W)) u_pick (
      .req   (expired),
      .grant (grant),
      .any   (any_exp),
      .idx   (pick_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmo_pulse <= 1'b0;
         tmo_tag   <= '0;
         proto_err <= 1'b0;
      end else begin
         tmo_pulse <= any_exp;
         if (any_exp) tmo_tag <= pick_idx;
         if (req_vld && outstanding[req_tag]) proto_err <= 1'b1;
      end
   end

   // R6
   pulse_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_pulse |-> !outstanding[tmo_tag]);

   // R6
   pulse_was_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_pulse |-> ((($past(outstanding) >> tmo_tag) & NTAGS'(1)) != '0));

   // R7
   cpl_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_vld && outstanding[cpl_tag]) |=> !(tmo_pulse && tmo_tag == $past(cpl_tag)));

   // R8
   proto_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);

endmodule

// File: tb/cpl_timeout_monitor_bench.sv
module cpl_timeout_monitor_bench;
   localparam int NTAGS = 8;
   localparam int AGE_W = 8;
   localparam int TAG_W = 3;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             req_vld, req_is_cfg, cpl_vld, tick;
   logic [TAG_W-1:0] req_tag, cpl_tag;
   logic [31:0]      ctl_word;
   logic [AGE_W-1:0] limit;
   logic             tmo_pulse, proto_err;
   logic [TAG_W-1:0] tmo_tag;
   logic [NTAGS-1:0] outstanding;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   cpl_timeout_monitor u_cpl_timeout_monitor (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_tag(req_tag),
      .req_is_cfg(req_is_cfg), .cpl_vld(cpl_vld), .cpl_tag(cpl_tag),
      .tick(tick), .ctl_word(ctl_word), .limit(limit),
      .tmo_pulse(tmo_pulse), .tmo_tag(tmo_tag),
      .outstanding(outstanding), .proto_err(proto_err)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic set_en(logic cfg, logic ncfg);
      ctl_word = '0;
      ctl_word[22] = ncfg;
      ctl_word[23] = cfg;
      step();
   endtask

   task automatic issue(int tag, logic cfg);
      req_vld = 1'b1; req_tag = TAG_W'(tag); req_is_cfg = cfg;
      step();
      req_vld = 1'b0; req_is_cfg = 1'b0;
   endtask

   task automatic complete(int tag);
      cpl_vld = 1'b1; cpl_tag = TAG_W'(tag);
      step();
      cpl_vld = 1'b0;
   endtask

   task automatic ticks(int n);
      tick = 1'b1;
      repeat (n) step();
      tick = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_vld = 1'b0; req_is_cfg = 1'b0; cpl_vld = 1'b0;
      tick = 1'b0; req_tag = '0; cpl_tag = '0; ctl_word = '0; limit = 8'd3;
      repeat (3) step();
      chk("R1", "outstanding", int'(outstanding), 0);
      chk("R1", "tmo_pulse", int'(tmo_pulse), 0);
      chk("R1", "proto_err", int'(proto_err), 0);
      rst_n = 1'b1;
      step();

      // R3 R4 R5 R6 sweep over tag, class and enables
      for (int tg = 0; tg < NTAGS; tg++) begin
         for (int e = 0; e < 4; e++) begin
            for (int c = 0; c < 2; c++) begin
               logic ce, ne, expect_to;
               ce = e[1]; ne = e[0];
               expect_to = ne && (c == 0 || ce);
               set_en(ce, ne);
               issue(tg, c[0]);
               ticks(3);
               chk(c ? "R4" : "R3", "pulse before due", int'(tmo_pulse), 0);
               chk("R3", "still outstanding at limit", int'(outstanding[tg]), 1);
               step();
               chk(c ? "R4" : "R3", "pulse when due", int'(tmo_pulse), int'(expect_to));
               chk("R6", "retired", int'(outstanding[tg]), int'(!expect_to));
               if (expect_to) begin
                  chk("R6", "tmo_tag", int'(tmo_tag), tg);
                  step();
                  chk("R6", "single cycle", int'(tmo_pulse), 0);
               end else begin
                  ticks(4);
                  step();
                  chk("R5", "no pulse when disabled", int'(tmo_pulse), 0);
                  chk("R5", "waits when disabled", int'(outstanding[tg]), 1);
                  complete(tg);
                  chk("R2", "completion clears", int'(outstanding[tg]), 0);
               end
            end
         end
      end

      // R2 stray completion
      set_en(1'b0, 1'b0);
      issue(3, 1'b0);
      complete(4);
      chk("R2", "stray completion ignored", int'(outstanding), 8);
      complete(3);
      chk("R2", "completion clears", int'(outstanding), 0);

      // R7 completion wins at expiry
      set_en(1'b0, 1'b1);
      issue(2, 1'b0);
      ticks(3);
      complete(2);
      chk("R7", "no pulse", int'(tmo_pulse), 0);
      chk("R7", "cleared", int'(outstanding), 0);
      step();
      chk("R7", "no late pulse", int'(tmo_pulse), 0);

      // R8 duplicate issue
      chk("R8", "proto_err clear", int'(proto_err), 0);
      issue(5, 1'b0);
      ticks(2);
      issue(5, 1'b1);
      chk("R8", "proto_err set", int'(proto_err), 1);
      ticks(1);
      step();
      chk("R8", "age and class kept", int'(tmo_pulse), 1);
      chk("R8", "tag", int'(tmo_tag), 5);
      repeat (3) step();
      chk("R8", "proto_err sticky", int'(proto_err), 1);

      // R9 enable change on outstanding request
      set_en(1'b0, 1'b0);
      issue(0, 1'b0);
      ticks(5);
      step();
      chk("R9", "no pulse while off", int'(tmo_pulse), 0);
      ctl_word[22] = 1'b1;
      step();
      chk("R9", "no pulse on sampling edge", int'(tmo_pulse), 0);
      step();
      chk("R9", "pulse next cycle", int'(tmo_pulse), 1);
      chk("R9", "tag", int'(tmo_tag), 0);

      // R10 simultaneous expiry
      set_en(1'b0, 1'b1);
      issue(6, 1'b0);
      issue(1, 1'b0);
      ticks(3);
      step();
      chk("R10", "first pulse", int'(tmo_pulse), 1);
      chk("R10", "lowest tag first", int'(tmo_tag), 1);
      chk("R10", "other still live", int'(outstanding), 64);
      step();
      chk("R10", "second pulse", int'(tmo_pulse), 1);
      chk("R10", "second tag", int'(tmo_tag), 6);
      step();
      chk("R10", "done", int'(tmo_pulse), 0);

      // R11 saturation
      limit = 8'd255;
      set_en(1'b0, 1'b0);
      issue(7, 1'b0);
      ticks(265);
      ctl_word[22] = 1'b1;
      step();
      chk("R11", "no pulse on sampling edge", int'(tmo_pulse), 0);
      step();
      chk("R11", "saturated age meets max limit", int'(tmo_pulse), 1);
      chk("R11", "tag", int'(tmo_tag), 7);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule